// File: doc/BRIEF.md
# Per-Processor Interrupt Request Latch and Router

This block sits between the per-processor interrupt selectors and the processors' interrupt pins of a multi-processor interrupt controller. Each processor has its own request latch. The latch captures the selector's winning request, which is a priority, a source index and a valid flag. It is the pipeline stage that closes the two-cycle selector path, so it normally loads a new value on every clock.

While a processor runs an acknowledge cycle, its latch freezes. The vector returned to that processor therefore cannot change, even if a more urgent request wins the selector in the meantime.

A router per processor decides whether to raise that processor's interrupt pin. It compares the latched request against three things:
- the highest priority currently in service for that processor, which arrives as a bitmap;
- the processor's current task priority;
- a per-processor destination mask indexed by source.

The pin is registered. It drops in the cycle after an acknowledge begins. When the acknowledge ends, the router evaluates the held vector again.

Top module: `irq_latch_router`

## Requirements
- R1: Each processor (NCPU, default 2) has its own latch and pin. An acknowledge or request on one processor never changes another processor's outputs.
- R2: While a processor's acknowledge input is low, its latched outputs (`vec_valid_o`, `vec_prio_o`, `vec_src_o`) equal the selector inputs sampled at the previous rising clock edge.
- R3: While a processor's acknowledge input is high at a clock edge, its latched outputs keep their value, even if the selector presents a different or higher-priority request.
- R4: The interrupt pin becomes 1 at the edge after the latch holds a request that meets all four conditions below. This is two edges after the selector presents it.
  - The request is valid.
  - Its priority is strictly above the task priority.
  - Its priority is strictly above the in-service ceiling.
  - Its destination bit is set.
- R5: A latched request that is not valid, or that has priority 0, never raises the pin.
- R6: A latched priority equal to the task priority or equal to the in-service ceiling does not raise the pin.
- R7: In the 16-bit in-service bitmap, bit p set means priority p is in service. The ceiling is the highest set bit among bits 1..15, and bit 0 is ignored.
- R8: Bit s of a processor's destination mask (NSRC = 25 bits) enables source s for that processor. A latched source index of NSRC or more never raises the pin.
- R9: The pin reads 0 after any edge at which that processor's acknowledge input is high. At the first edge with acknowledge low again, the pin is recomputed from the held vector.
- R10: While reset (`rst_n` low, asynchronous) is asserted, all latched fields and all interrupt pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid_i | input | NCPU | Selector winner valid, one bit per processor |
| sel_prio_i | input | NCPU*4 | Selector winner priority, processor c at bits [4c+3:4c] |
| sel_src_i | input | NCPU*5 | Selector winner source index, processor c at bits [5c+4:5c] |
| ack_i | input | NCPU | Acknowledge cycle in progress, one bit per processor |
| isr_map_i | input | NCPU*16 | In-service priority bitmap, processor c at bits [16c+15:16c] |
| task_prio_i | input | NCPU*4 | Current task priority, processor c at bits [4c+3:4c] |
| dest_mask_i | input | NCPU*25 | Destination enable per source, processor c at bits [25c+24:25c] |
| vec_valid_o | output | NCPU | Latched request valid |
| vec_prio_o | output | NCPU*4 | Latched priority |
| vec_src_o | output | NCPU*5 | Latched source index |
| int_o | output | NCPU | Interrupt pin per processor |

## Verification
Two functions can land on the same clock edge: the latch capturing a new selector winner, and the start of an acknowledge that must freeze the latch and drop the pin. The bench provokes this by raising acknowledge on exactly the edge where the selector's winner jumps to a higher priority. It judges that the old vector survives and the pin falls, and that the new winner appears only after acknowledge ends. The other processor keeps running through that window, which shows that its latch and pin are unaffected.

// File: rtl/irq_lr_pkg.sv
package irq_lr_pkg;
    // Default geometry of the request latch and router
    localparam int unsigned DEF_NCPU   = 2;
    localparam int unsigned DEF_PRIO_W = 4;
    localparam int unsigned DEF_SRC_W  = 5;
    localparam int unsigned DEF_NSRC   = 25;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int unsigned PRIO_W = 4,
    parameter int unsigned SRC_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_i,
    input  logic              sel_valid_i,
    input  logic [PRIO_W-1:0] sel_prio_i,
    input  logic [SRC_W-1:0]  sel_src_i,
    output logic              lat_valid_o,
    output logic [PRIO_W-1:0] lat_prio_o,
    output logic [SRC_W-1:0]  lat_src_o
);
    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [SRC_W-1:0]  src;
    } req_t;

    req_t lat_d, lat_q;

    // Frozen during acknowledge, otherwise the pipeline stage after the selector
    always_comb begin
        lat_d = lat_q;
        if (!ack_i) begin
            lat_d.valid = sel_valid_i;
            lat_d.prio  = sel_prio_i;
            lat_d.src   = sel_src_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign lat_valid_o = lat_q.valid;
    assign lat_prio_o  = lat_q.prio;
    assign lat_src_o   = lat_q.src;

    assert_hold_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ack_i) |-> $stable(lat_valid_o) && $stable(lat_prio_o) && $stable(lat_src_o));

    assert_follow_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(ack_i) |->
            lat_valid_o == $past(sel_valid_i) && lat_prio_o == $past(sel_prio_i) && lat_src_o == $past(sel_src_i));
endmodule

// File: rtl/irq_isr_ceiling.sv
module irq_isr_ceiling #(
    parameter int unsigned PRIO_W = 4,
    localparam int unsigned NLVL  = 1 << PRIO_W
) (
    input  logic [NLVL-1:0]   map_i,
    output logic [PRIO_W-1:0] ceil_o
);
    // Highest set level among 1..NLVL-1; level 0 means nothing in service
    always_comb begin
        ceil_o = '0;
        for (int lvl = 1; lvl < NLVL; lvl++) begin
            if (map_i[lvl]) ceil_o = PRIO_W'(lvl);
        end
    end
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router #(
    parameter int unsigned PRIO_W = 4,
    parameter int unsigned SRC_W  = 5,
    parameter int unsigned NSRC   = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_i,
    input  logic              lat_valid_i,
    input  logic [PRIO_W-1:0] lat_prio_i,
    input  logic [SRC_W-1:0]  lat_src_i,
    input  logic [PRIO_W-1:0] ceil_i,
    input  logic [PRIO_W-1:0] task_i,
    input  logic [NSRC-1:0]   dest_i,
    output logic              int_o
);
    typedef struct packed {
        logic pin;
    } rt_t;

    rt_t  rt_d, rt_q;
    logic dest_hit;

    // Destination lookup; indices at or above NSRC never match
    always_comb begin
        dest_hit = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            if (lat_src_i == SRC_W'(s)) dest_hit = dest_i[s];
        end
    end

    always_comb begin
        rt_d = rt_q;
        if (ack_i) begin
            rt_d.pin = 1'b0;
        end else begin
            rt_d.pin = lat_valid_i && (lat_prio_i != '0) && (lat_prio_i > task_i)
                       && (lat_prio_i > ceil_i) && dest_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign int_o = rt_q.pin;

    assert_drop_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !int_o);

    assert_nonzero_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> $past(lat_valid_i) && $past(lat_prio_i) != '0);

    assert_strict_over_task_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> $past(lat_prio_i) > $past(task_i) && $past(lat_prio_i) > $past(ceil_i));

    assert_src_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> $past(lat_src_i) < SRC_W'(NSRC));
endmodule

// File: rtl/irq_latch_router.sv
module irq_latch_router
    import irq_lr_pkg::*;
#(
    parameter int unsigned NCPU   = DEF_NCPU,
    parameter int unsigned PRIO_W = DEF_PRIO_W,
    parameter int unsigned SRC_W  = DEF_SRC_W,
    parameter int unsigned NSRC   = DEF_NSRC,
    localparam int unsigned NLVL  = 1 << PRIO_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCPU-1:0]        sel_valid_i,
    input  logic [NCPU*PRIO_W-1:0] sel_prio_i,
    input  logic [NCPU*SRC_W-1:0]  sel_src_i,
    input  logic [NCPU-1:0]        ack_i,
    input  logic [NCPU*NLVL-1:0]   isr_map_i,
    input  logic [NCPU*PRIO_W-1:0] task_prio_i,
    input  logic [NCPU*NSRC-1:0]   dest_mask_i,
    output logic [NCPU-1:0]        vec_valid_o,
    output logic [NCPU*PRIO_W-1:0] vec_prio_o,
    output logic [NCPU*SRC_W-1:0]  vec_src_o,
    output logic [NCPU-1:0]        int_o
);
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic              lat_valid;
        logic [PRIO_W-1:0] lat_prio;
        logic [SRC_W-1:0]  lat_src;
        logic [PRIO_W-1:0] ceil;

        irq_req_latch #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_latch (
            .clk         (clk),
            .rst_n       (rst_n),
            .ack_i       (ack_i[c]),
            .sel_valid_i (sel_valid_i[c]),
            .sel_prio_i  (sel_prio_i[c*PRIO_W +: PRIO_W]),
            .sel_src_i   (sel_src_i[c*SRC_W +: SRC_W]),
            .lat_valid_o (lat_valid),
            .lat_prio_o  (lat_prio),
            .lat_src_o   (lat_src)
        );

        irq_isr_ceiling #(.PRIO_W(PRIO_W)) u_ceil (
            .map_i  (isr_map_i[c*NLVL +: NLVL]),
            .ceil_o (ceil)
        );

        irq_pin_router #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .NSRC(NSRC)) u_router (
            .clk         (clk),
            .rst_n       (rst_n),
            .ack_i       (ack_i[c]),
            .lat_valid_i (lat_valid),
            .lat_prio_i  (lat_prio),
            .lat_src_i   (lat_src),
            .ceil_i      (ceil),
            .task_i      (task_prio_i[c*PRIO_W +: PRIO_W]),
            .dest_i      (dest_mask_i[c*NSRC +: NSRC]),
            .int_o       (int_o[c])
        );

        assign vec_valid_o[c]                  = lat_valid;
        assign vec_prio_o[c*PRIO_W +: PRIO_W]  = lat_prio;
        assign vec_src_o[c*SRC_W +: SRC_W]     = lat_src;

        // R7: the pin can only be high over a request above the ceiling seen at the previous edge
        assert_above_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
            int_o[c] |-> !$past(isr_map_i[c*NLVL + int'(lat_prio)]));
    end
endmodule

// File: tb/irq_latch_router_test.sv
module irq_latch_router_test;
    localparam int NCPU = 2;
    localparam int PW   = 4;
    localparam int SW   = 5;
    localparam int NS   = 25;
    localparam int NL   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCPU-1:0]    sel_valid = '0;
    logic [NCPU*PW-1:0] sel_prio  = '0;
    logic [NCPU*SW-1:0] sel_src   = '0;
    logic [NCPU-1:0]    ack       = '0;
    logic [NCPU*NL-1:0] isr_map   = '0;
    logic [NCPU*PW-1:0] task_prio = '0;
    logic [NCPU*NS-1:0] dest_mask = '0;
    logic [NCPU-1:0]    vec_valid;
    logic [NCPU*PW-1:0] vec_prio;
    logic [NCPU*SW-1:0] vec_src;
    logic [NCPU-1:0]    int_pin;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_latch_router uut (
        .clk(clk), .rst_n(rst_n),
        .sel_valid_i(sel_valid), .sel_prio_i(sel_prio), .sel_src_i(sel_src),
        .ack_i(ack), .isr_map_i(isr_map), .task_prio_i(task_prio),
        .dest_mask_i(dest_mask),
        .vec_valid_o(vec_valid), .vec_prio_o(vec_prio), .vec_src_o(vec_src),
        .int_o(int_pin)
    );

    typedef struct {
        int    cpu;
        bit    e_int;
        bit    e_valid;
        int    e_prio;
        int    e_src;
        string tag;
    } exp_t;

    exp_t sb[$];

    // Reference model state, per requirements
    bit m_valid [NCPU];
    int m_prio  [NCPU];
    int m_src   [NCPU];

    function automatic int ceiling(input logic [NL-1:0] m);
        int r = 0;
        for (int l = 1; l < NL; l++) if (m[l]) r = l;
        return r;
    endfunction

    function automatic bit should_fire(input int c);
        int tp = int'(task_prio[c*PW +: PW]);
        int cl = ceiling(isr_map[c*NL +: NL]);
        bit dh = (m_src[c] < NS) ? dest_mask[c*NS + m_src[c]] : 1'b0;
        return m_valid[c] && m_prio[c] != 0 && m_prio[c] > tp && m_prio[c] > cl && dh;
    endfunction

    task automatic set_cpu(input int c, input bit v, input int p, input int s,
                           input int tp, input logic [NL-1:0] im, input logic [NS-1:0] dm);
        sel_valid[c]          = v;
        sel_prio[c*PW +: PW]  = PW'(p);
        sel_src[c*SW +: SW]   = SW'(s);
        task_prio[c*PW +: PW] = PW'(tp);
        isr_map[c*NL +: NL]   = im;
        dest_mask[c*NS +: NS] = dm;
    endtask

    // Driver: inputs are already set at a falling edge; predict the state after the next rising edge
    task automatic step(input string tag);
        for (int c = 0; c < NCPU; c++) begin
            exp_t e;
            bit   fire;
            fire = ack[c] ? 1'b0 : should_fire(c);
            if (!ack[c]) begin
                m_valid[c] = sel_valid[c];
                m_prio[c]  = int'(sel_prio[c*PW +: PW]);
                m_src[c]   = int'(sel_src[c*SW +: SW]);
            end
            e.cpu = c; e.e_int = fire; e.e_valid = m_valid[c];
            e.e_prio = m_prio[c]; e.e_src = m_src[c]; e.tag = tag;
            sb.push_back(e);
        end
        @(negedge clk);
    endtask

    // Monitor: sample a quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        while (sb.size() > 0) begin
            exp_t e;
            int   c;
            e = sb.pop_front();
            c = e.cpu;
            total++;
            if (int_pin[c] !== e.e_int || vec_valid[c] !== e.e_valid ||
                int'(vec_prio[c*PW +: PW]) != e.e_prio || int'(vec_src[c*SW +: SW]) != e.e_src) begin
                bad++;
                $display("FAIL %s cpu%0d: got int=%0b v=%0b p=%0d s=%0d expected int=%0b v=%0b p=%0d s=%0d",
                         e.tag, c, int_pin[c], vec_valid[c], vec_prio[c*PW +: PW], vec_src[c*SW +: SW],
                         e.e_int, e.e_valid, e.e_prio, e.e_src);
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCPU; c++) begin m_valid[c] = 0; m_prio[c] = 0; m_src[c] = 0; end
        set_cpu(0, 1, 9, 4, 0, '0, '1);
        set_cpu(1, 1, 7, 2, 0, '0, '1);
        #15;
        // R10: reset clears everything even with requests pending
        total++;
        if (vec_valid !== '0 || vec_prio !== '0 || vec_src !== '0 || int_pin !== '0) begin
            bad++;
            $display("FAIL R10 reset: got v=%0h p=%0h s=%0h int=%0h expected all zero",
                     vec_valid, vec_prio, vec_src, int_pin);
        end
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R4: latch follows; pin rises one edge later
        set_cpu(0, 1, 5, 3, 2, '0, '1);
        set_cpu(1, 0, 0, 0, 0, '0, '1);
        step("R2 capture");
        step("R4 fire");
        set_cpu(0, 1, 11, 24, 10, '0, '1);
        step("R2 new winner");
        step("R4 top source");

        // R6: equal to task, then equal to ceiling
        set_cpu(0, 1, 6, 1, 6, '0, '1);
        step("R6 eq task");
        step("R6 eq task");
        set_cpu(0, 1, 6, 1, 0, 16'h0040, '1);
        step("R6 eq ceiling");
        step("R6 eq ceiling");
        // R7: ceiling is highest set bit; bit 0 ignored
        set_cpu(0, 1, 6, 1, 0, 16'h0021, '1);
        step("R7 below ceiling fires");
        step("R7 below ceiling fires");
        set_cpu(0, 1, 1, 1, 0, 16'h0001, '1);
        step("R7 bit0 ignored");
        step("R7 bit0 ignored");
        set_cpu(0, 1, 8, 1, 0, 16'h8002, '1);
        step("R7 top bit ceiling");
        step("R7 top bit ceiling");

        // R5: priority zero / invalid
        set_cpu(0, 1, 0, 2, 0, '0, '1);
        step("R5 prio zero");
        step("R5 prio zero");
        set_cpu(0, 0, 9, 2, 0, '0, '1);
        step("R5 invalid");
        step("R5 invalid");

        // R8: destination mask bit and out-of-range source
        set_cpu(0, 1, 9, 7, 0, '0, ~(25'd1 << 7));
        step("R8 dest off");
        step("R8 dest off");
        set_cpu(0, 1, 9, 7, 0, '0, 25'd1 << 7);
        step("R8 dest only");
        step("R8 dest only");
        set_cpu(0, 1, 9, 27, 0, '0, '1);
        step("R8 src out of range");
        step("R8 src out of range");

        // R3/R9/R1: acknowledge starts on the edge a higher winner arrives
        set_cpu(0, 1, 5, 3, 0, '0, '1);
        set_cpu(1, 1, 4, 10, 1, '0, '1);
        step("R9 setup");
        step("R9 setup");
        ack[0] = 1'b1;
        set_cpu(0, 1, 14, 20, 0, '0, '1);
        set_cpu(1, 1, 12, 11, 1, '0, '1);
        step("R3 R9 ack start");
        set_cpu(0, 1, 15, 21, 0, '0, '1);
        set_cpu(1, 1, 3, 12, 1, '0, '1);
        step("R3 R1 hold");
        step("R3 R1 hold");
        ack[0] = 1'b0;
        step("R9 ack end reevaluate");
        step("R2 after ack");
        // R1: acknowledge on the other processor only
        ack[1] = 1'b1;
        set_cpu(1, 1, 13, 5, 0, '0, '1);
        step("R1 cpu1 ack");
        ack[1] = 1'b0;
        step("R1 cpu1 release");
        step("R1 cpu1 release");

        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule